// File: doc/BRIEF.md
# Byte-Wide Erasable Programmable Memory Model

This block is a synthesizable behavioural model of a byte-wide programmable read-only memory. It can be programmed once, or again after erasure. It is placed in a simulation or on an FPGA as the target device when programmer logic is being tested. Two active-low controls gate it. The chip-select line governs power and selection. The output-gate line governs the data pins. Two digital flags stand in for analog levels: one for the raised programming supply and one for an overdriven address line. The data bus is split into an input byte, an output byte and an output-drive flag. The drive flag stands for the pins leaving high impedance.

Every control, address and data input passes through two register stages. The output byte and its drive flag are registered as well. A level change at the inputs therefore shows at the outputs after the third rising clock edge. A write is committed when the synchronised chip-select line returns high after a low phase. On that write the word becomes its old value ANDed with the applied byte, so programming can only clear bits. The synchronous erase input returns every word to all ones in a single cycle. The memory is built from a plain RAM plus one "written" flag per word, so the RAM can map to block memory.

Top module: `eprom_model`

## Requirements
- R1: After reset the output drive flag is 0, the output byte is 00h, and every word reads FFh.
- R2: With chip select low, output gate low, programming flag low and high-voltage address flag low, the model drives the byte stored at the address. The value appears after the third rising clock edge following the input change.
- R3: With chip select high and the programming flag low, the drive flag is 0 for either level of output gate.
- R4: With chip select low, output gate high and the programming flag low, the drive flag is 0. A chip-select pulse in this state writes nothing.
- R5: A write stores the old word ANDed with the applied byte. A 1 in the applied byte never sets a cleared bit.
- R6: A write happens only when the synchronised chip-select line rises. In the last low cycle before that rise, the programming flag must be 1 and output gate must be high. While chip select is low in that state, the drive flag is 0.
- R7: With the programming flag 1, output gate low and chip select high, the model drives the stored byte at the address.
- R8: With the programming flag 1 and both enables high, the drive flag is 0 and no word changes.
- R9: With the high-voltage address flag 1 and the read conditions of R2 otherwise met, the model drives an identifier byte selected by address bit 0 only. Bit 0 = 0 returns 20h and bit 0 = 1 returns 41h.
- R10: A one-cycle erase pulse makes every word read FFh afterwards.
- R11: With the programming flag 1 and both enables low, the drive flag is 0. Whenever the drive flag is 0, the output byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Byte applied for programming |
| ce_n_i | input | 1 | Chip select, active low (power and write strobe) |
| oe_n_i | input | 1 | Output gate, active low |
| vpp_hi_i | input | 1 | Programming supply raised |
| a9_hi_i | input | 1 | Identifier address line overdriven |
| erase_i | input | 1 | Synchronous erase to all ones |
| dout_o | output | DATA_W | Output byte, 00h when not driven |
| dout_en_o | output | 1 | Output pins actively driven |

## Verification
The bench builds the model with DEPTH = 16 and a 4-bit address. At that size the bench can read back every word after reset and after an erase, and it keeps a full shadow copy of the array. The small depth also puts address bit 0 next to ordinary data words, so the identifier selection can be checked at an odd address other than 1. Repeated programming of one word exposes the AND accumulation, and pulses under the output-disable and inhibit conditions confirm that nothing is written.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_READ,
    MD_OFF,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT,
    MD_SIG,
    MD_CONFLICT
  } eprom_mode_e;

  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_PART  = 8'h41;

endpackage

// File: rtl/eprom_in_stage.sv
module eprom_in_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              vpp_i,
  input  logic              a9_i,
  input  logic              erase_i,
  output logic [ADDR_W-1:0] addr_s1_o,
  output logic [ADDR_W-1:0] addr_s2_o,
  output logic [DATA_W-1:0] din_s2_o,
  output logic              ce_n_s2_o,
  output logic              oe_n_s2_o,
  output logic              vpp_s2_o,
  output logic              a9_s2_o,
  output logic              erase_s1_o,
  output logic              commit_o
);

  logic ce_n_s1, oe_n_s1, vpp_s1, a9_s1;
  logic [DATA_W-1:0] din_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_s1_o  <= '0;
      din_s1     <= '0;
      ce_n_s1    <= 1'b1;
      oe_n_s1    <= 1'b1;
      vpp_s1     <= 1'b0;
      a9_s1      <= 1'b0;
      erase_s1_o <= 1'b0;
      addr_s2_o  <= '0;
      din_s2_o   <= '0;
      ce_n_s2_o  <= 1'b1;
      oe_n_s2_o  <= 1'b1;
      vpp_s2_o   <= 1'b0;
      a9_s2_o    <= 1'b0;
    end else begin
      addr_s1_o  <= addr_i;
      din_s1     <= din_i;
      ce_n_s1    <= ce_n_i;
      oe_n_s1    <= oe_n_i;
      vpp_s1     <= vpp_i;
      a9_s1      <= a9_i;
      erase_s1_o <= erase_i;
      addr_s2_o  <= addr_s1_o;
      din_s2_o   <= din_s1;
      ce_n_s2_o  <= ce_n_s1;
      oe_n_s2_o  <= oe_n_s1;
      vpp_s2_o   <= vpp_s1;
      a9_s2_o    <= a9_s1;
    end
  end

  // Strobe rises: stage 1 high, stage 2 still low; stage 2 holds the last low-phase conditions
  assign commit_o = ce_n_s1 & ~ce_n_s2_o & vpp_s2_o & oe_n_s2_o;

  // R6: a commit is only ever raised while the strobe is being released
  p_commit_edge_r6: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> (ce_n_s2_o && !$past(ce_n_s2_o)));

endmodule

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic        ce_n_i,
  input  logic        oe_n_i,
  input  logic        vpp_i,
  input  logic        a9_i,
  output eprom_mode_e mode_o
);

  always_comb begin
    if (ce_n_i) begin
      if (!vpp_i)      mode_o = MD_STANDBY;
      else if (oe_n_i) mode_o = MD_INHIBIT;
      else             mode_o = MD_VERIFY;
    end else if (oe_n_i) begin
      mode_o = vpp_i ? MD_PROG : MD_OFF;
    end else if (vpp_i) begin
      mode_o = MD_CONFLICT;
    end else begin
      mode_o = a9_i ? MD_SIG : MD_READ;
    end
  end

endmodule

// File: rtl/eprom_store.sv
module eprom_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              erase_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] ram_q;
  logic [DEPTH-1:0]  written;
  logic              written_q;

  // Plain synchronous RAM, read-before-write, no reset: maps to block memory
  always_ff @(posedge clk) begin
    if (wr_en_i) ram[wr_addr_i] <= wr_data_i;
    ram_q <= ram[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst || erase_i) begin
      written   <= '0;
      written_q <= 1'b0;
    end else begin
      if (wr_en_i) written[wr_addr_i] <= 1'b1;
      written_q <= written[rd_addr_i];
    end
  end

  // Never-written words read as the erased pattern
  assign rd_data_o = written_q ? ram_q : {DATA_W{1'b1}};

  p_erase_all_r10: assert property (@(posedge clk) disable iff (rst)
    erase_i |=> (written == '0) && (rd_data_o == {DATA_W{1'b1}}));

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              vpp_hi_i,
  input  logic              a9_hi_i,
  input  logic              erase_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);

  logic [ADDR_W-1:0] addr_s1, addr_s2;
  logic [DATA_W-1:0] din_s2, stored;
  logic ce_n_s2, oe_n_s2, vpp_s2, a9_s2, erase_s1, commit;
  eprom_mode_e mode;

  eprom_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .addr_i(addr_i), .din_i(din_i),
    .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .vpp_i(vpp_hi_i), .a9_i(a9_hi_i),
    .erase_i(erase_i), .addr_s1_o(addr_s1), .addr_s2_o(addr_s2),
    .din_s2_o(din_s2), .ce_n_s2_o(ce_n_s2), .oe_n_s2_o(oe_n_s2),
    .vpp_s2_o(vpp_s2), .a9_s2_o(a9_s2), .erase_s1_o(erase_s1),
    .commit_o(commit)
  );

  eprom_mode_dec u_dec (
    .ce_n_i(ce_n_s2), .oe_n_i(oe_n_s2), .vpp_i(vpp_s2), .a9_i(a9_s2),
    .mode_o(mode)
  );

  // Stored word always lines up with addr_s2 (RAM read issued one stage earlier)
  eprom_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .rd_addr_i(addr_s1),
    .wr_en_i(commit & ~erase_s1), .wr_addr_i(addr_s2),
    .wr_data_i(stored & din_s2), .erase_i(erase_s1),
    .rd_data_o(stored)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o    <= '0;
      dout_en_o <= 1'b0;
    end else begin
      case (mode)
        MD_READ, MD_VERIFY: begin
          dout_o    <= stored;
          dout_en_o <= 1'b1;
        end
        MD_SIG: begin
          dout_o    <= addr_s2[0] ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER);
          dout_en_o <= 1'b1;
        end
        default: begin
          dout_o    <= '0;
          dout_en_o <= 1'b0;
        end
      endcase
    end
  end

  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_READ) |=> dout_en_o && (dout_o == $past(stored)));
  p_standby_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_STANDBY) |=> !dout_en_o);
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_OFF) |=> !dout_en_o);
  p_prog_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PROG) |=> !dout_en_o);
  p_verify_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_VERIFY) |=> dout_en_o && (dout_o == $past(stored)));
  p_inhibit_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_INHIBIT) |=> !dout_en_o);
  p_sig_code_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_SIG) |=> dout_en_o &&
      (dout_o == ($past(addr_s2[0]) ? DATA_W'(8'h41) : DATA_W'(8'h20))));
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !dout_en_o |-> (dout_o == '0));

endmodule

// File: tb/sim_eprom_model.sv
module sim_eprom_model;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp = 1'b0, a9 = 1'b0, erase = 1'b0;
  logic [7:0] dout;
  logic dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] shadow [DEPTH];

  always #(TCLK/2) clk = ~clk;

  eprom_model #(.DEPTH(DEPTH), .DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr), .din_i(din), .ce_n_i(ce_n),
    .oe_n_i(oe_n), .vpp_hi_i(vpp), .a9_hi_i(a9), .erase_i(erase),
    .dout_o(dout), .dout_en_o(dout_en)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: en/data actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_ctl(logic c, logic o, logic v, logic h);
    ce_n = c; oe_n = o; vpp = v; a9 = h;
  endtask

  task automatic rd_word(string req, int a, logic [7:0] exp);
    addr = AW'(a);
    set_ctl(0, 0, 0, 0);
    settle();
    check(req, {dout_en, dout}, {1'b1, exp});
  endtask

  task automatic prog(int a, logic [7:0] d);
    addr = AW'(a); din = d;
    set_ctl(1, 1, 1, 0);
    @(negedge clk);
    ce_n = 0;
    repeat (2) @(negedge clk);
    ce_n = 1;
    settle();
    shadow[a] = shadow[a] & d;
  endtask

  task automatic t_reset();
    check("R1 reset drive", {dout_en, dout}, 9'h000);
    for (int i = 0; i < DEPTH; i++) rd_word("R1 erased after reset", i, 8'hFF);
  endtask

  task automatic t_program();
    prog(5, 8'hA5);
    addr = 5; set_ctl(1, 0, 1, 0); settle();
    check("R7 verify after program", {dout_en, dout}, {1'b1, 8'hA5});
    prog(5, 8'h0F);
    rd_word("R5 AND accumulate", 5, 8'h05);
    prog(5, 8'hFF);
    rd_word("R5 ones do not restore", 5, 8'h05);
    rd_word("R2 neighbour untouched", 6, 8'hFF);
    prog(9, 8'h3C);
    rd_word("R2 read programmed word", 9, shadow[9]);
  endtask

  task automatic t_pulse_quiet();
    addr = 10; din = 8'h00;
    set_ctl(1, 1, 1, 0); @(negedge clk);
    ce_n = 0; settle();
    check("R6 outputs off during pulse", {dout_en, dout}, 9'h000);
    ce_n = 1; settle();
    shadow[10] = 8'h00;
    rd_word("R6 pulse committed", 10, 8'h00);
  endtask

  task automatic t_standby();
    addr = 9;
    set_ctl(1, 0, 0, 0); settle();
    check("R3 standby oe low", {dout_en, dout}, 9'h000);
    set_ctl(1, 1, 0, 0); settle();
    check("R3 standby oe high", {dout_en, dout}, 9'h000);
  endtask

  task automatic t_outoff();
    addr = 7; din = 8'h00;
    set_ctl(0, 1, 0, 0); settle();
    check("R4 output disable", {dout_en, dout}, 9'h000);
    ce_n = 1; @(negedge clk); ce_n = 0; repeat (2) @(negedge clk); ce_n = 1; settle();
    rd_word("R4 no write without vpp", 7, 8'hFF);
  endtask

  task automatic t_inhibit();
    addr = 8; din = 8'h00;
    set_ctl(1, 1, 1, 0); settle();
    check("R8 inhibit quiet", {dout_en, dout}, 9'h000);
    rd_word("R8 no write while inhibited", 8, 8'hFF);
    // write strobe with output gate low (verify conditions) must not write
    set_ctl(1, 0, 1, 0); @(negedge clk);
    ce_n = 0; repeat (2) @(negedge clk); ce_n = 1; settle();
    rd_word("R6 no write with gate low", 8, 8'hFF);
  endtask

  task automatic t_sig();
    addr = 0; set_ctl(0, 0, 0, 1); settle();
    check("R9 maker byte", {dout_en, dout}, {1'b1, 8'h20});
    addr = 1; settle();
    check("R9 part byte", {dout_en, dout}, {1'b1, 8'h41});
    addr = 5; settle();
    check("R9 bit0 only selects", {dout_en, dout}, {1'b1, 8'h41});
    addr = 10; settle();
    check("R9 even addr maker", {dout_en, dout}, {1'b1, 8'h20});
  endtask

  task automatic t_conflict();
    addr = 5; set_ctl(0, 0, 1, 0); settle();
    check("R11 vpp with both enables low", {dout_en, dout}, 9'h000);
  endtask

  task automatic t_erase();
    prog(3, 8'h12);
    rd_word("R5 fresh word", 3, 8'h12);
    set_ctl(1, 1, 0, 0);
    @(negedge clk); erase = 1; @(negedge clk); erase = 0;
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = 8'hFF;
      rd_word("R10 erased", i, 8'hFF);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_program();
    t_pulse_quiet();
    t_standby();
    t_outoff();
    t_inhibit();
    t_sig();
    t_conflict();
    t_erase();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

endmodule